// File: doc/BRIEF.md
# Trap-Level Privileged Control Register File

This block keeps the privileged control state of one processor core: the address space identifier, processor state, trap level, interrupt level, window pointer, global level, trap base address, hyperprivileged state and a strand status word. Beside these scalars it holds five stacks with one entry per trap level: trap PC, trap next PC, trap state, trap type and hyper trap state. An access to any of the five stacks always reaches the entry picked by the current trap level.

The pipeline reaches the file through one read port and one write port. Each port carries an enable and a 6-bit register index. A read is combinational and returns the value held before any write in the same cycle. A write is registered. Each register shapes the data written to it in its own way: some bits are masked, the window pointer is clamped and the trap level saturates. An index the block does not serve raises an error flag on the port that used it. A write to the trap level also updates a registered trap-level-zero interrupt request, using the hyperprivileged state.

Top module: `priv_csr_file`

## Requirements
- R1: Index map: 0 address space id (8 bits), 1 FP register state (3 bits), 2 processor state, 3 trap level, 4 interrupt level (4 bits), 5 window pointer, 6 global level (3 bits), 7 trap base, 8 hyperprivileged state (64 bits), 9 strand status (64 bits). After reset, index 8 reads 0x800, index 9 reads 0x50000, tlz_irq is 0, and every other register reads 0.
- R2: A write commits at the next rising edge. A read of the same index in the same cycle returns the old value.
- R3: A write to processor state keeps only the bits in mask 0x13DE (bits 1-4, 6-9 and 12) and stores every other bit as zero.
- R4: A write to the trap base stores the value with bits 14:0 cleared.
- R5: A window pointer write of NWIN (default 8) or more, compared on all 64 bits, stores NWIN-1.
- R6: A read of FP register state returns the stored 3-bit value with bits 1:0 forced to 1.
- R7: A write to the trap level sets tlz_irq in the next cycle if the written value is zero, hyperprivileged bit 0 is 1 and hyperprivileged bit 2 is 0. In every other case that write clears tlz_irq. No other access changes tlz_irq.
- R8: Indices 16 trap PC, 17 trap next PC, 18 trap state, 19 trap type and 20 hyper trap state each select one entry per trap level. An access reaches entry (trap level - 1), so values written at different levels stay separate.
- R9: A read or write of indices 16-20 while the trap level is 0 raises the error flag of that port, reads 0, and changes no entry.
- R10: Indices 24 and 25 (performance control and counter), 26 and 27 (interrupt set and clear aliases), and every other index outside 0-9 and 16-20 raise the error flag of the port on a read or a write. A read of such an index returns 0, and a write to it changes no register.
- R11: A trap level write above MAX_TL (default 6) stores MAX_TL. Writes to narrow registers keep only their low bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read request |
| rd_idx | input | 6 | Read register index |
| rd_data | output | 64 | Read value, combinational, 0 on error |
| rd_err | output | 1 | Read targeted a bad index or an empty stack level |
| wr_en | input | 1 | Write request |
| wr_idx | input | 6 | Write register index |
| wr_data | input | 64 | Write value |
| wr_err | output | 1 | Write refused; no state changes |
| tlz_irq | output | 1 | Trap-level-zero interrupt request, registered |

## Verification
The read data and both error flags are combinational, so they are due in the same cycle as the request that causes them. A written value becomes visible to a read one edge later, and tlz_irq also changes one edge after the trap level write. The driver applies each operation just after a falling edge and queues what it expects. The monitor compares five nanoseconds later, so combinational results are taken in their own cycle, and register and interrupt results are checked by the operation issued on the following cycle.

// File: rtl/priv_csr_pkg.sv
package priv_csr_pkg;

    localparam int XLEN  = 64;
    localparam int IDX_W = 6;

    // scalar register indices
    localparam logic [IDX_W-1:0] IDX_ASI     = 6'd0;
    localparam logic [IDX_W-1:0] IDX_FPRS    = 6'd1;
    localparam logic [IDX_W-1:0] IDX_PSTATE  = 6'd2;
    localparam logic [IDX_W-1:0] IDX_TL      = 6'd3;
    localparam logic [IDX_W-1:0] IDX_PIL     = 6'd4;
    localparam logic [IDX_W-1:0] IDX_CWP     = 6'd5;
    localparam logic [IDX_W-1:0] IDX_GL      = 6'd6;
    localparam logic [IDX_W-1:0] IDX_TBASE   = 6'd7;
    localparam logic [IDX_W-1:0] IDX_HPST    = 6'd8;
    localparam logic [IDX_W-1:0] IDX_STRAND  = 6'd9;
    // per-level stacks
    localparam logic [IDX_W-1:0] IDX_BANK_LO = 6'd16;
    localparam logic [IDX_W-1:0] IDX_BANK_HI = 6'd20;
    localparam int               NUM_BANKED  = 5;

    localparam logic [XLEN-1:0] PSTATE_KEEP = 64'h0000_0000_0000_13DE;
    localparam logic [XLEN-1:0] TBASE_KEEP  = ~64'h0000_0000_0000_7FFF;
    localparam logic [XLEN-1:0] HPST_RST    = 64'h0000_0000_0000_0800;
    localparam logic [XLEN-1:0] STRAND_RST  = 64'h0000_0000_0005_0000;

    localparam int HP_TLZ_BIT   = 0;
    localparam int HP_HPRIV_BIT = 2;

    typedef enum logic [1:0] {
        ACC_SCALAR = 2'd0,
        ACC_BANKED = 2'd1,
        ACC_BAD    = 2'd2
    } acc_kind_e;

endpackage

// File: rtl/priv_csr_decode.sv
module priv_csr_decode
    import priv_csr_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output acc_kind_e        kind,
    output logic [2:0]       field
);

    always_comb begin
        kind  = ACC_BAD;
        field = 3'(idx - IDX_BANK_LO);
        if (idx <= IDX_STRAND) begin
            kind = ACC_SCALAR;
        end else if (idx >= IDX_BANK_LO && idx <= IDX_BANK_HI) begin
            kind = ACC_BANKED;
        end
    end

endmodule

// File: rtl/priv_csr_wnorm.sv
module priv_csr_wnorm
    import priv_csr_pkg::*;
#(
    parameter int NWIN   = 8,
    parameter int MAX_TL = 6
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [XLEN-1:0]  din,
    output logic [XLEN-1:0]  dout
);

    localparam logic [XLEN-1:0] CWP_TOP = XLEN'(NWIN - 1);
    localparam logic [XLEN-1:0] TL_TOP  = XLEN'(MAX_TL);

    always_comb begin
        dout = din;
        case (idx)
            IDX_PSTATE: dout = din & PSTATE_KEEP;
            IDX_TBASE:  dout = din & TBASE_KEEP;
            IDX_CWP:    dout = (din > CWP_TOP) ? CWP_TOP : din;
            IDX_TL:     dout = (din > TL_TOP) ? TL_TOP : din;
            default:    dout = din;
        endcase
    end

endmodule

// File: rtl/priv_csr_tstack.sv
module priv_csr_tstack #(
    parameter int DEPTH = 6,
    parameter int WIDTH = 64,
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [LVL_W-1:0] lvl,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem_d [DEPTH];
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
            if (we && lvl == LVL_W'(i)) begin
                mem_d[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                mem_q[i] <= '0;
            end else begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (lvl == LVL_W'(i)) begin
                rdata = mem_q[i];
            end
        end
    end

endmodule

// File: rtl/priv_csr_file.sv
module priv_csr_file
    import priv_csr_pkg::*;
#(
    parameter int NWIN   = 8,
    parameter int MAX_TL = 6,
    parameter int GL_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [XLEN-1:0]  rd_data,
    output logic             rd_err,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [XLEN-1:0]  wr_data,
    output logic             wr_err,
    output logic             tlz_irq
);

    localparam int TL_W   = $clog2(MAX_TL + 1);
    localparam int CWP_W  = (NWIN > 1) ? $clog2(NWIN) : 1;
    localparam int LVL_W  = (MAX_TL > 1) ? $clog2(MAX_TL) : 1;
    localparam int PST_W  = 13;

    typedef struct packed {
        logic [7:0]       asi;
        logic [2:0]       fprs;
        logic [PST_W-1:0] pstate;
        logic [TL_W-1:0]  tl;
        logic [3:0]       pil;
        logic [CWP_W-1:0] cwp;
        logic [GL_W-1:0]  gl;
        logic [XLEN-1:0]  tbase;
        logic [XLEN-1:0]  hpst;
        logic [XLEN-1:0]  strand;
        logic             tlz;
    } state_t;

    state_t st_d, st_q;

    // taps shared by the datapath and the bound checker
    logic [TL_W-1:0]  tl_cur;
    logic [CWP_W-1:0] cwp_cur;
    logic [PST_W-1:0] pstate_cur;
    logic [XLEN-1:0]  hp_cur;
    logic             tl_zero;
    logic [LVL_W-1:0] lvl;

    assign tl_cur     = st_q.tl;
    assign cwp_cur    = st_q.cwp;
    assign pstate_cur = st_q.pstate;
    assign hp_cur     = st_q.hpst;
    assign tl_zero    = (tl_cur == '0);
    assign lvl        = LVL_W'(tl_cur - 1'b1);
    assign tlz_irq    = st_q.tlz;

    // ---------------- index decode, one per port ----------------
    acc_kind_e  rd_kind, wr_kind;
    logic [2:0] rd_field, wr_field;

    priv_csr_decode u_rd_dec (.idx(rd_idx), .kind(rd_kind), .field(rd_field));
    priv_csr_decode u_wr_dec (.idx(wr_idx), .kind(wr_kind), .field(wr_field));

    logic wr_ok;
    assign wr_ok  = wr_en && ((wr_kind == ACC_SCALAR) ||
                              (wr_kind == ACC_BANKED && !tl_zero));
    assign wr_err = wr_en && !wr_ok;

    // ---------------- write shaping ----------------
    logic [XLEN-1:0] wr_norm;

    priv_csr_wnorm #(.NWIN(NWIN), .MAX_TL(MAX_TL)) u_norm (
        .idx  (wr_idx),
        .din  (wr_data),
        .dout (wr_norm)
    );

    // ---------------- per-level stacks ----------------
    logic [XLEN-1:0] bank_rd [NUM_BANKED];

    for (genvar f = 0; f < NUM_BANKED; f++) begin : g_bank
        logic we_f;
        assign we_f = wr_ok && (wr_kind == ACC_BANKED) && (wr_field == 3'(f));

        priv_csr_tstack #(.DEPTH(MAX_TL), .WIDTH(XLEN), .LVL_W(LVL_W)) u_stack (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (we_f),
            .lvl   (lvl),
            .wdata (wr_data),
            .rdata (bank_rd[f])
        );
    end

    // ---------------- next state ----------------
    always_comb begin
        st_d = st_q;
        if (wr_ok && wr_kind == ACC_SCALAR) begin
            case (wr_idx)
                IDX_ASI:    st_d.asi    = wr_norm[7:0];
                IDX_FPRS:   st_d.fprs   = wr_norm[2:0];
                IDX_PSTATE: st_d.pstate = wr_norm[PST_W-1:0];
                IDX_TL: begin
                    st_d.tl  = wr_norm[TL_W-1:0];
                    st_d.tlz = (wr_norm == '0) && st_q.hpst[HP_TLZ_BIT] &&
                               !st_q.hpst[HP_HPRIV_BIT];
                end
                IDX_PIL:    st_d.pil    = wr_norm[3:0];
                IDX_CWP:    st_d.cwp    = wr_norm[CWP_W-1:0];
                IDX_GL:     st_d.gl     = wr_norm[GL_W-1:0];
                IDX_TBASE:  st_d.tbase  = wr_norm;
                IDX_HPST:   st_d.hpst   = wr_norm;
                IDX_STRAND: st_d.strand = wr_norm;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.hpst   <= HPST_RST;
            st_q.strand <= STRAND_RST;
        end else begin
            st_q <= st_d;
        end
    end

    // ---------------- read port ----------------
    always_comb begin
        rd_data = '0;
        rd_err  = 1'b0;
        if (rd_en) begin
            case (rd_kind)
                ACC_SCALAR: begin
                    case (rd_idx)
                        IDX_ASI:    rd_data = XLEN'(st_q.asi);
                        IDX_FPRS:   rd_data = XLEN'(st_q.fprs) | XLEN'(3);
                        IDX_PSTATE: rd_data = XLEN'(st_q.pstate);
                        IDX_TL:     rd_data = XLEN'(st_q.tl);
                        IDX_PIL:    rd_data = XLEN'(st_q.pil);
                        IDX_CWP:    rd_data = XLEN'(st_q.cwp);
                        IDX_GL:     rd_data = XLEN'(st_q.gl);
                        IDX_TBASE:  rd_data = st_q.tbase;
                        IDX_HPST:   rd_data = st_q.hpst;
                        IDX_STRAND: rd_data = st_q.strand;
                        default:    rd_data = '0;
                    endcase
                end
                ACC_BANKED: begin
                    if (tl_zero) begin
                        rd_err = 1'b1;
                    end else begin
                        for (int f = 0; f < NUM_BANKED; f++) begin
                            if (rd_field == 3'(f)) begin
                                rd_data = bank_rd[f];
                            end
                        end
                    end
                end
                default: rd_err = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/priv_csr_chk.sv
module priv_csr_chk
    import priv_csr_pkg::*;
#(
    parameter int NWIN   = 8,
    parameter int MAX_TL = 6,
    parameter int TL_W   = 3,
    parameter int CWP_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_en,
    input logic [IDX_W-1:0] rd_idx,
    input logic [XLEN-1:0]  rd_data,
    input logic             rd_err,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic [XLEN-1:0]  wr_data,
    input logic             wr_err,
    input logic             tlz_irq,
    input logic [TL_W-1:0]  tl_cur,
    input logic [CWP_W-1:0] cwp_cur,
    input logic [12:0]      pstate_cur,
    input logic [XLEN-1:0]  hp_cur
);

    a_r3_pstate_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate_cur & ~13'h13DE) == 13'h0);

    a_r5_cwp_bound: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cwp_cur) <= NWIN - 1);

    a_r11_tl_bound: assert property (@(posedge clk) disable iff (!rst_n)
        32'(tl_cur) <= MAX_TL);

    a_r6_fprs_low: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_idx == IDX_FPRS) |-> (rd_data[1:0] == 2'b11 && !rd_err));

    a_r9_bank_empty_rd: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_idx >= IDX_BANK_LO && rd_idx <= IDX_BANK_HI && tl_cur == '0)
        |-> (rd_err && rd_data == '0));

    a_r9_bank_empty_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx >= IDX_BANK_LO && wr_idx <= IDX_BANK_HI && tl_cur == '0)
        |-> wr_err);

    a_r10_perf_rd: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_idx >= 6'd24 && rd_idx <= 6'd27) |-> (rd_err && rd_data == '0));

    a_r10_perf_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx >= 6'd24 && wr_idx <= 6'd27) |-> wr_err);

    a_r7_tlz_update: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_TL && !wr_err) |=>
        (tlz_irq == ($past(wr_data) == '0 && $past(hp_cur[HP_TLZ_BIT]) &&
                     !$past(hp_cur[HP_HPRIV_BIT]))));

    a_r7_tlz_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_idx == IDX_TL) |=> $stable(tlz_irq));

endmodule

bind priv_csr_file priv_csr_chk #(
    .NWIN(NWIN), .MAX_TL(MAX_TL), .TL_W(TL_W), .CWP_W(CWP_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .rd_idx     (rd_idx),
    .rd_data    (rd_data),
    .rd_err     (rd_err),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .wr_err     (wr_err),
    .tlz_irq    (tlz_irq),
    .tl_cur     (tl_cur),
    .cwp_cur    (cwp_cur),
    .pstate_cur (pstate_cur),
    .hp_cur     (hp_cur)
);

// File: tb/test_priv_csr_file.sv
`timescale 1ns/1ps
module test_priv_csr_file;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic [5:0]  rd_idx = '0;
    logic [63:0] rd_data;
    logic        rd_err;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic        wr_err;
    logic        tlz_irq;

    always #10 clk = ~clk;

    priv_csr_file i_priv_csr_file (
        .clk(clk), .rst_n(rst_n),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data), .rd_err(rd_err),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_err(wr_err),
        .tlz_irq(tlz_irq)
    );

    typedef struct {
        bit          chk_rd;
        logic [63:0] rd;
        bit          rerr;
        bit          chk_wr;
        bit          werr;
        bit          chk_irq;
        bit          irq;
        string       tag;
    } exp_t;

    exp_t sbq[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    // ---------------- monitor ----------------
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                if (e.chk_rd) begin
                    checks++;
                    if (rd_data !== e.rd || rd_err !== e.rerr) begin
                        errors++;
                        $display("FAIL %s: read data=%h err=%b, expected data=%h err=%b",
                                 e.tag, rd_data, rd_err, e.rd, e.rerr);
                    end
                end
                if (e.chk_wr) begin
                    checks++;
                    if (wr_err !== e.werr) begin
                        errors++;
                        $display("FAIL %s: wr_err=%b, expected %b", e.tag, wr_err, e.werr);
                    end
                end
                if (e.chk_irq) begin
                    checks++;
                    if (tlz_irq !== e.irq) begin
                        errors++;
                        $display("FAIL %s: tlz_irq=%b, expected %b", e.tag, tlz_irq, e.irq);
                    end
                end
            end
        end
    end

    // ---------------- driver ----------------
    function automatic exp_t blank(input string tag);
        exp_t e;
        e.chk_rd = 0; e.rd = '0; e.rerr = 0;
        e.chk_wr = 0; e.werr = 0;
        e.chk_irq = 0; e.irq = 0;
        e.tag = tag;
        return e;
    endfunction

    task automatic op(input logic re, input logic [5:0] ri, input logic we,
                      input logic [5:0] wi, input logic [63:0] wd, input exp_t e);
        @(negedge clk);
        rd_en = re; rd_idx = ri; wr_en = we; wr_idx = wi; wr_data = wd;
        sbq.push_back(e);
    endtask

    task automatic rd(input logic [5:0] i, input logic [63:0] x, input bit err, input string tag);
        exp_t e;
        e = blank(tag);
        e.chk_rd = 1; e.rd = x; e.rerr = err;
        op(1'b1, i, 1'b0, 6'd0, 64'd0, e);
    endtask

    task automatic wr(input logic [5:0] i, input logic [63:0] d, input bit err, input string tag);
        exp_t e;
        e = blank(tag);
        e.chk_wr = 1; e.werr = err;
        op(1'b0, 6'd0, 1'b1, i, d, e);
    endtask

    task automatic irq(input bit x, input string tag);
        exp_t e;
        e = blank(tag);
        e.chk_irq = 1; e.irq = x;
        op(1'b0, 6'd0, 1'b0, 6'd0, 64'd0, e);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd(6'd0, 64'h0, 0, "R1 asi reset");
        rd(6'd2, 64'h0, 0, "R1 pstate reset");
        rd(6'd3, 64'h0, 0, "R1 tl reset");
        rd(6'd5, 64'h0, 0, "R1 cwp reset");
        rd(6'd7, 64'h0, 0, "R1 tbase reset");
        rd(6'd8, 64'h800, 0, "R1 hpstate reset");
        rd(6'd9, 64'h50000, 0, "R1 strand reset");
        rd(6'd1, 64'h3, 0, "R1 R6 fprs reset read");
        irq(1'b0, "R1 tlz_irq reset");

        // R9 stacks empty at level zero
        rd(6'd16, 64'h0, 1, "R9 read stack at tl0");
        wr(6'd16, 64'hDEAD, 1, "R9 write stack at tl0");

        // R3 processor state mask
        wr(6'd2, '1, 0, "R3 pstate write");
        rd(6'd2, 64'h13DE, 0, "R3 pstate all ones");
        wr(6'd2, 64'h1021, 0, "R3 pstate write");
        rd(6'd2, 64'h1000, 0, "R3 pstate sparse");

        // R4 trap base
        wr(6'd7, '1, 0, "R4 tbase write");
        rd(6'd7, 64'hFFFF_FFFF_FFFF_8000, 0, "R4 tbase all ones");
        wr(6'd7, 64'h12345, 0, "R4 tbase write");
        rd(6'd7, 64'h10000, 0, "R4 tbase pattern");

        // R5 window pointer clamp
        wr(6'd5, 64'd5, 0, "R5 cwp write");
        rd(6'd5, 64'd5, 0, "R5 cwp in range");
        wr(6'd5, 64'd8, 0, "R5 cwp write");
        rd(6'd5, 64'd7, 0, "R5 cwp equal to NWIN");
        wr(6'd5, 64'h1_0000_0002, 0, "R5 cwp write");
        rd(6'd5, 64'd7, 0, "R5 cwp high bits");
        wr(6'd5, 64'd3, 0, "R5 cwp write");
        rd(6'd5, 64'd3, 0, "R5 cwp back in range");

        // R6 FP register state
        wr(6'd1, 64'd4, 0, "R6 fprs write");
        rd(6'd1, 64'd7, 0, "R6 fprs read forced");
        wr(6'd1, 64'd0, 0, "R6 fprs write");
        rd(6'd1, 64'd3, 0, "R6 fprs zero read");

        // R2 read during write sees old value
        begin
            exp_t e;
            e = blank("R2 same cycle read");
            e.chk_rd = 1; e.rd = 64'h0; e.chk_wr = 1;
            op(1'b1, 6'd0, 1'b1, 6'd0, 64'h5A, e);
        end
        rd(6'd0, 64'h5A, 0, "R2 value after edge");

        // R11 narrow registers
        wr(6'd0, 64'h1FF, 0, "R11 asi write");
        rd(6'd0, 64'hFF, 0, "R11 asi truncated");
        wr(6'd4, 64'h1F, 0, "R11 pil write");
        rd(6'd4, 64'hF, 0, "R11 pil truncated");
        wr(6'd6, 64'hF, 0, "R11 gl write");
        rd(6'd6, 64'h7, 0, "R11 gl truncated");

        // R8 per-level stacks
        wr(6'd3, 64'd1, 0, "R8 tl=1");
        wr(6'd16, 64'h111, 0, "R8 tpc at level 1");
        wr(6'd19, 64'h22, 0, "R8 tt at level 1");
        wr(6'd3, 64'd2, 0, "R8 tl=2");
        wr(6'd16, 64'h222, 0, "R8 tpc at level 2");
        rd(6'd16, 64'h222, 0, "R8 tpc level 2");
        rd(6'd19, 64'h0, 0, "R8 tt level 2 untouched");
        wr(6'd3, 64'd1, 0, "R8 tl=1");
        rd(6'd16, 64'h111, 0, "R8 tpc level 1");
        rd(6'd19, 64'h22, 0, "R8 tt level 1");

        // R11 trap level saturation
        wr(6'd3, 64'd6, 0, "R11 tl=6");
        wr(6'd20, 64'h66, 0, "R11 htstate at level 6");
        wr(6'd3, 64'd9, 0, "R11 tl write above max");
        rd(6'd3, 64'd6, 0, "R11 tl saturated");
        rd(6'd20, 64'h66, 0, "R11 R8 htstate top level");
        rd(6'd17, 64'h0, 0, "R8 tnpc top level");

        // R9 refused access changes nothing
        wr(6'd3, 64'd0, 0, "R9 tl=0");
        wr(6'd16, 64'hDEAD, 1, "R9 tpc write at tl0");
        rd(6'd17, 64'h0, 1, "R9 tnpc read at tl0");
        wr(6'd3, 64'd1, 0, "R9 tl=1");
        rd(6'd16, 64'h111, 0, "R9 tpc unchanged");

        // R7 trap-level-zero interrupt
        wr(6'd3, 64'd0, 0, "R7 tl=0 tlz clear");
        irq(1'b0, "R7 no irq without tlz bit");
        wr(6'd8, 64'h1, 0, "R7 hpstate tlz set");
        wr(6'd3, 64'd0, 0, "R7 tl=0");
        irq(1'b1, "R7 irq raised");
        wr(6'd0, 64'h3, 0, "R7 other write");
        irq(1'b1, "R7 irq held");
        wr(6'd3, 64'd1, 0, "R7 tl=1");
        irq(1'b0, "R7 irq cleared");
        wr(6'd8, 64'h5, 0, "R7 hpstate hpriv set");
        wr(6'd3, 64'd0, 0, "R7 tl=0 under hpriv");
        irq(1'b0, "R7 hpriv blocks irq");
        rd(6'd8, 64'h5, 0, "R7 hpstate stored");

        // R10 rejected indices
        rd(6'd24, 64'h0, 1, "R10 perf ctl read");
        rd(6'd25, 64'h0, 1, "R10 perf cnt read");
        rd(6'd26, 64'h0, 1, "R10 set alias read");
        rd(6'd27, 64'h0, 1, "R10 clr alias read");
        rd(6'd40, 64'h0, 1, "R10 unknown read");
        rd(6'd10, 64'h0, 1, "R10 gap read");
        wr(6'd24, 64'h1, 1, "R10 perf ctl write");
        wr(6'd27, 64'h1, 1, "R10 alias write");
        wr(6'd63, 64'h1, 1, "R10 unknown write");
        rd(6'd0, 64'h3, 0, "R10 asi unchanged");
        rd(6'd3, 64'h0, 0, "R10 tl unchanged");

        wr(6'd9, 64'h1234, 0, "R1 strand write");
        rd(6'd9, 64'h1234, 0, "R1 strand read");

        begin
            exp_t e;
            e = blank("idle");
            op(1'b0, 6'd0, 1'b0, 6'd0, 64'd0, e);
        end
        while (sbq.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule